// File: doc/BRIEF.md
# Two-Slot Elastic Pipeline Stage

This block is one register stage for a channel that uses a valid/ready handshake. It can hold up to two flits. While the downstream side accepts data, each flit passes through with one cycle of latency and the stage sustains one flit per cycle. When the downstream side stalls, the stage absorbs the flit that was already in flight before its own ready drops. This keeps the ready path registered and free of bubbles. A chain of these stages along a long wire therefore behaves as a distributed FIFO whose depth grows with the channel length.

Control is a three-state machine: empty, one flit held, and two flits held. The state is coded in two bits. Upstream ready is the inverse of the upper bit, and downstream valid is a copy of the lower bit, so both handshake outputs come straight from flops. A primary slot always drives the output. A secondary slot catches the flit that arrives during a stall, and that flit moves into the primary slot when the stall clears. Reset is asynchronous and active low.

Top module: `ebuf2_stage`

## Requirements
- R1: While rst_n is low, and after it is released until the first accepted flit, valid_out is 0 and ready_out is 1.
- R2: ready_out is 0 exactly when two flits are held, and 1 when zero or one flit is held.
- R3: valid_out is 1 exactly when at least one flit is held.
- R4: A flit moves on an interface only at a rising clock edge where that interface's valid and ready are both 1. data_in is ignored at edges where ready_out or valid_in is 0.
- R5: Occupancy changes as follows. Empty plus valid_in goes to one. One plus valid_in with ready_in low goes to two. One with no valid_in and ready_in high goes to empty. One with both valid_in and ready_in stays at one and passes the flit through. Two plus ready_in goes to one.
- R6: When one flit is held and ready_in is 0, data_out keeps the same value at the next edge, even if a new flit is accepted at that edge.
- R7: When two flits are held and ready_in is 0, neither slot is written. data_out stays stable, ready_out stays 0, and offered input is dropped by the sender's own hold rule.
- R8: Flits leave in arrival order. When two flits are held, the older one is on data_out, and the newer one appears on data_out at the edge where the older one leaves.
- R9: A chain of stages under random stalls at both ends delivers every flit once, in order. With no stalls, it sustains one flit per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| valid_in | input | 1 | Upstream flit valid |
| data_in | input | DATA_W | Upstream flit data |
| ready_out | output | 1 | Stage can accept a flit (not full) |
| valid_out | output | 1 | Stage presents a flit (not empty) |
| data_out | output | DATA_W | Oldest held flit |
| ready_in | input | 1 | Downstream accepts the presented flit |

## Verification
A wrong state value shows at the handshake outputs on the very next edge, because ready_out and valid_out are direct copies of the state bits. An occupancy error therefore appears as a premature or missing ready or valid within one cycle. Wrong slot steering may leave both handshakes looking correct. It shows up instead as a changed data_out during a stall, or as a duplicated, lost or reordered flit. The ordering check catches this when the affected flit leaves, which can be several stall cycles later. For that reason the directed table samples data_out after every edge, and the chained run compares every delivered flit against a queue.

// File: rtl/ebuf2_pkg.sv
package ebuf2_pkg;
  // State coding: bit[1] gates acceptance, bit[0] marks output validity.
  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_ONE   = 2'b01,
    ST_FULL  = 2'b11
  } eb_state_t;
endpackage

// File: rtl/ebuf2_ctrl.sv
module ebuf2_ctrl
  import ebuf2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid_in,
  input  logic ready_in,
  output logic ready_out,
  output logic valid_out,
  output logic pri_en,
  output logic pri_from_sec,
  output logic sec_en
);
  eb_state_t st_q, st_d;
  logic acc_in, snd_out;

  assign ready_out = ~st_q[1];
  assign valid_out = st_q[0];
  assign acc_in    = valid_in & ready_out;
  assign snd_out   = valid_out & ready_in;

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_EMPTY: if (valid_in) st_d = ST_ONE;
      ST_ONE: begin
        if (acc_in && !snd_out)      st_d = ST_FULL;
        else if (!acc_in && snd_out) st_d = ST_EMPTY;
      end
      ST_FULL:  if (ready_in) st_d = ST_ONE;
      default:  st_d = ST_EMPTY;
    endcase
  end

  // slot enables
  always_comb begin
    pri_en       = 1'b0;
    pri_from_sec = 1'b0;
    sec_en       = 1'b0;
    unique case (st_q)
      ST_EMPTY: pri_en = valid_in;
      ST_ONE: begin
        pri_en = valid_in & ready_in;
        sec_en = valid_in & ~ready_in;
      end
      ST_FULL: begin
        pri_en       = ready_in;
        pri_from_sec = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_EMPTY;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/ebuf2_slots.sv
module ebuf2_slots #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] data_in,
  input  logic              pri_en,
  input  logic              pri_from_sec,
  input  logic              sec_en,
  output logic [DATA_W-1:0] data_out
);
  logic [DATA_W-1:0] pri_q, sec_q, pri_d;

  always_comb pri_d = pri_from_sec ? sec_q : data_in;

  always_ff @(posedge clk) begin
    if (pri_en) pri_q <= pri_d;
  end

  always_ff @(posedge clk) begin
    if (sec_en) sec_q <= data_in;
  end

  assign data_out = pri_q;
endmodule

// File: rtl/ebuf2_stage.sv
module ebuf2_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              ready_out,
  output logic              valid_out,
  output logic [DATA_W-1:0] data_out,
  input  logic              ready_in
);
  logic pri_en, pri_from_sec, sec_en;

  ebuf2_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_in     (valid_in),
    .ready_in     (ready_in),
    .ready_out    (ready_out),
    .valid_out    (valid_out),
    .pri_en       (pri_en),
    .pri_from_sec (pri_from_sec),
    .sec_en       (sec_en)
  );

  ebuf2_slots #(.DATA_W(DATA_W)) slots_i (
    .clk          (clk),
    .data_in      (data_in),
    .pri_en       (pri_en),
    .pri_from_sec (pri_from_sec),
    .sec_en       (sec_en),
    .data_out     (data_out)
  );
endmodule

// File: rtl/ebuf2_stage_chk.sv
module ebuf2_stage_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_in,
  input logic              ready_out,
  input logic              valid_out,
  input logic [DATA_W-1:0] data_out,
  input logic              ready_in
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!valid_out && ready_out));

  a_r2_full_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_out |-> valid_out);

  a_r3_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && ready_out) |=> valid_out);

  a_r5_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && ready_out && ready_in && !valid_in) |=> !valid_out);

  a_r5_full_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_out && ready_in) |=> (ready_out && valid_out));

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && !ready_in) |=> (valid_out && $stable(data_out)));

  a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_out && !ready_in) |=> !ready_out);
endmodule

bind ebuf2_stage ebuf2_stage_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_in  (valid_in),
  .ready_out (ready_out),
  .valid_out (valid_out),
  .data_out  (data_out),
  .ready_in  (ready_in)
);

// File: tb/ebuf2_stage_tb_top.sv
module ebuf2_stage_tb_top;
  localparam int W      = 8;
  localparam int NSTG   = 4;
  localparam int NROWS  = 12;
  localparam int NFLITS = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // single stage
  logic         vin = 1'b0, rin = 1'b0;
  logic [W-1:0] din = '0;
  logic         rout, vout;
  logic [W-1:0] dout;

  ebuf2_stage #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid_in(vin), .data_in(din),
    .ready_out(rout), .valid_out(vout), .data_out(dout), .ready_in(rin)
  );

  // chain of stages
  logic         c_v [NSTG+1];
  logic         c_r [NSTG+1];
  logic [W-1:0] c_d [NSTG+1];
  logic         src_v = 1'b0, snk_r = 1'b0;
  logic [W-1:0] src_d = '0;

  assign c_v[0]    = src_v;
  assign c_d[0]    = src_d;
  assign c_r[NSTG] = snk_r;

  for (genvar g = 0; g < NSTG; g++) begin : chain_g
    ebuf2_stage #(.DATA_W(W)) stg_i (
      .clk(clk), .rst_n(rst_n), .valid_in(c_v[g]), .data_in(c_d[g]),
      .ready_out(c_r[g]), .valid_out(c_v[g+1]), .data_out(c_d[g+1]),
      .ready_in(c_r[g+1])
    );
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // row: vin, din, rin, exp valid, exp ready, exp data
  localparam logic [19:0] VEC [NROWS] = '{
    {1'b1, 8'h11, 1'b0, 1'b1, 1'b1, 8'h11}, // R5 empty->one
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h11}, // R6 stall, one held
    {1'b1, 8'h22, 1'b0, 1'b1, 1'b0, 8'h11}, // R6 R5 accept on stall -> full
    {1'b1, 8'h33, 1'b0, 1'b1, 1'b0, 8'h11}, // R7 R4 full stall, input ignored
    {1'b1, 8'h44, 1'b1, 1'b1, 1'b1, 8'h22}, // R8 R4 older leaves, newer promoted
    {1'b1, 8'h55, 1'b1, 1'b1, 1'b1, 8'h55}, // R5 pass-through
    {1'b0, 8'h66, 1'b1, 1'b0, 1'b1, 8'h00}, // R5 drain -> empty, R4 data ignored
    {1'b0, 8'h77, 1'b1, 1'b0, 1'b1, 8'h00}, // R4 empty, nothing offered
    {1'b1, 8'h88, 1'b1, 1'b1, 1'b1, 8'h88}, // R5 empty->one
    {1'b1, 8'h99, 1'b0, 1'b1, 1'b0, 8'h88}, // R5 one->full
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h99}, // R8 full->one
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00}  // R5 one->empty
  };

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] expq[$];
    int sent, rcvd, run, streak;
    logic prev_fire;

    // R1 during reset
    repeat (3) @(negedge clk);
    check("R1 valid_out in reset", W'(vout), W'(0));
    check("R1 ready_out in reset", W'(rout), W'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid_out after release", W'(vout), W'(0));
    check("R1 ready_out after release", W'(rout), W'(1));

    // vector table
    for (int i = 0; i < NROWS; i++) begin
      vin = VEC[i][19];
      din = VEC[i][18:11];
      rin = VEC[i][10];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R3 valid_out row %0d", i), W'(vout), W'(VEC[i][9]));
      check($sformatf("R2 ready_out row %0d", i), W'(rout), W'(VEC[i][8]));
      if (VEC[i][9]) check($sformatf("R8 R6 data_out row %0d", i), dout, VEC[i][7:0]);
    end

    // R1 reset while full
    vin = 1'b1; din = 8'hA1; rin = 1'b0;
    @(negedge clk);
    din = 8'hA2;
    @(negedge clk);
    vin = 1'b0;
    check("R2 full before reset", W'(rout), W'(0));
    rst_n = 1'b0;
    #1;
    check("R1 async reset valid_out", W'(vout), W'(0));
    check("R1 async reset ready_out", W'(rout), W'(1));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stays empty after release", W'(vout), W'(0));

    // R9 chain under random stalls
    sent = 0; rcvd = 0; run = 0; prev_fire = 1'b1;
    while (rcvd < NFLITS && run < 20000) begin
      @(negedge clk);
      run++;
      if (prev_fire || !src_v) begin
        if (sent < NFLITS && ($urandom_range(3) != 0)) begin
          src_v = 1'b1;
          src_d = W'($urandom);
        end else begin
          src_v = 1'b0;
        end
      end
      snk_r = ($urandom_range(2) != 0);
      #0;
      prev_fire = src_v && c_r[0];
      if (prev_fire) begin
        expq.push_back(src_d);
        sent++;
      end
      if (c_v[NSTG] && snk_r) begin
        if (expq.size() == 0) begin
          total++; bad++;
          $display("FAIL R9 unexpected flit actual=%0h expected=none", c_d[NSTG]);
        end else begin
          check("R9 in-order delivery", c_d[NSTG], expq.pop_front());
        end
        rcvd++;
      end
    end
    src_v = 1'b0;
    check("R9 all flits delivered", W'(rcvd), W'(NFLITS));

    // R9 full-rate streaming, no stalls
    snk_r = 1'b1;
    repeat (NSTG + 2) @(negedge clk);
    streak = 0;
    for (int k = 0; k < 20 + NSTG; k++) begin
      @(negedge clk);
      src_v = (k < 20);
      src_d = W'(k + 8'h40);
      #0;
      if (c_v[NSTG]) begin
        check("R9 streaming data", c_d[NSTG], W'(streak + 8'h40));
        streak++;
      end
    end
    src_v = 1'b0;
    check("R9 one flit per cycle", W'(streak), W'(20));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule